// File: doc/BRIEF.md
# Startup Boot-Override Tag Reader

This block is a small I2C master that runs exactly once after reset. It fetches an eight-byte ASCII tag from an optional EEPROM on a side bus, then turns that tag into a forced boot-source request for the boot sequencer. It does a random read. First it writes the register offset to the device. Then it sends a repeated START, readdresses the device for reading, and clocks in eight bytes.

The eight bytes are compared with three fixed tags. A match gives a valid flag and a 2-bit source code. An unknown tag gives no override. So does a missing device or an unanswered offset. The sequencer waits on `done`. After `done` rises, `override_valid` and `boot_src` keep their values until the next reset. The bus lines are open-drain. The block only pulls each line low and reads SDA back. SCL is made from the system clock by a parameterised divider.

The machine has six named states: IDLE, START, TX, RX, STOP and DONE. Every transition happens on the last of four quarter-bit phases:
- IDLE → START.
- START → TX.
- TX → TX, moving to the next bit or the next byte.
- TX → START, the repeated start after the offset byte.
- TX → RX, after the read address.
- TX → STOP, on a NACK.
- RX → RX.
- RX → STOP, after the last byte.
- STOP → DONE.

Top module: `boot_tag_reader`

## Requirements
- R1: While reset is held, and until the read completes, `done`, `override_valid` and `boot_src` are 0. While reset is held, both bus lines are released.
- R2: The transaction is sent in this order:
  - START.
  - Address byte 0xA4, which is 7-bit address 0x52 with the write bit 0.
  - Offset byte 0xF8.
  - Repeated START.
  - Address byte 0xA5, which has the read bit 1.
- R3: Exactly eight bytes are read. The master ACKs bytes 1 to 7, NACKs byte 8, and then sends STOP.
- R4: The bytes are compared in arrival order, with the first byte as the leftmost character. If they spell "boot@USB", the block reports valid=1 and code 01.
- R5: If the bytes spell "boot@SDC", the block reports valid=1 and code 10.
- R6: If the bytes spell "boot@SPI", the block reports valid=1 and code 11.
- R7: Any other eight-byte content, including a case or a single-character difference, gives valid=0 and code 00.
- R8: If the address byte is NACKed, the block sends STOP, raises `done` and reports valid=0 with code 00.
- R9: If the offset byte is NACKed, the block sends STOP, raises `done` and reports valid=0 with code 00.
- R10: `done` rises once. After that, `done`, `override_valid` and `boot_src` stay fixed and both lines stay released until reset.
- R11: SDA changes only while SCL is low, except at START and STOP. One SCL period equals 4×CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts the read |
| sda_i | input | 1 | Sensed level of the shared SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | Read finished (success or failure), sticky |
| override_valid | output | 1 | A known tag was found |
| boot_src | output | 2 | 00 none, 01 USB, 10 SD, 11 SPI-NOR |

## Verification
The bench runs seven cases:
- The three valid tags. These separate the code mapping from the bare comparison.
- Two near-miss tags, one differing only in its last character and one differing only in case. These show that the match is exact over all 64 bits and not over a prefix.
- An absent device and a device that refuses the offset. These exercise both failure exits of the TX state and show that a NACK never leaves a stale code behind.

An EEPROM model in the bench records the address bytes, the offset and the master's ACK/NACK pattern, so each run also confirms the shape of the transaction.

// File: rtl/boot_tag_pkg.sv
package boot_tag_pkg;

    localparam int TAG_BYTES = 8;
    localparam int TAG_BITS  = TAG_BYTES * 8;
    localparam int TAG_COUNT = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_USB  = 2'b01,
        SRC_SD   = 2'b10,
        SRC_NOR  = 2'b11
    } boot_src_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_TX,
        S_RX,
        S_STOP,
        S_DONE
    } rd_state_e;

    // Tag text: the first character on the wire sits in the top byte.
    localparam logic [TAG_BITS-1:0] TAG_TEXT [TAG_COUNT] = '{"boot@USB", "boot@SDC", "boot@SPI"};
    localparam boot_src_e           TAG_SRC  [TAG_COUNT] = '{SRC_USB, SRC_SD, SRC_NOR};

endpackage

// File: rtl/qtr_tick.sv
module qtr_tick #(
    parameter int DIV = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= '0;
        else if (en)     cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R11: quarter-bit ticks are never back to back
            p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tag_match.sv
module tag_match
    import boot_tag_pkg::*;
(
    input  logic [TAG_BITS-1:0] word,
    output boot_src_e           src
);
    logic [TAG_COUNT-1:0] hit;

    generate
        for (genvar i = 0; i < TAG_COUNT; i++) begin : g_cmp
            assign hit[i] = (word == TAG_TEXT[i]);
        end
    endgenerate

    always_comb begin
        src = SRC_NONE;
        for (int i = TAG_COUNT - 1; i >= 0; i--) begin
            if (hit[i]) src = TAG_SRC[i];
        end
    end

endmodule

// File: rtl/boot_tag_reader.sv
module boot_tag_reader
    import boot_tag_pkg::*;
#(
    parameter int         CLK_DIV    = 63,
    parameter logic [6:0] DEV_ADDR   = 7'h52,
    parameter logic [7:0] REG_OFFSET = 8'hF8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_i,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       done,
    output logic       override_valid,
    output logic [1:0] boot_src
);
    localparam logic [3:0] SEG_AW   = 4'd0;
    localparam logic [3:0] SEG_OFF  = 4'd1;
    localparam logic [3:0] SEG_AR   = 4'd2;
    localparam logic [3:0] SEG_LAST = 4'(SEG_AR + TAG_BYTES);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    rd_state_e          state;
    logic [1:0]         ph;
    logic [3:0]         bitn;
    logic [3:0]         seg;
    logic               samp;
    logic               fail;
    logic [TAG_BITS-1:0] shreg;
    logic [7:0]         tx_byte;
    logic [2:0]         tx_idx;
    logic               tick;
    boot_src_e          match;
    boot_src_e          src_q;

    qtr_tick #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state != S_DONE),
        .tick (tick)
    );

    tag_match u_match (
        .word(shreg),
        .src (match)
    );

    always_comb begin
        unique case (seg)
            SEG_AW:  tx_byte = {DEV_ADDR, 1'b0};
            SEG_OFF: tx_byte = REG_OFFSET;
            default: tx_byte = {DEV_ADDR, 1'b1};
        endcase
    end
    assign tx_idx = 3'(4'd7 - bitn);

    // State register: all progress happens on quarter-bit ticks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ph    <= '0;
            bitn  <= '0;
            seg   <= SEG_AW;
            samp  <= 1'b1;
            fail  <= 1'b0;
            shreg <= '0;
        end else if (tick) begin
            ph <= ph + 2'd1;
            if (ph == 2'd2) samp <= sda_i;
            if (state == S_RX && ph == 2'd2 && bitn != ACK_SLOT)
                shreg <= {shreg[TAG_BITS-2:0], sda_i};
            if (ph == 2'd3) begin
                unique case (state)
                    S_IDLE:  state <= S_START;
                    S_START: begin
                        state <= S_TX;
                        bitn  <= '0;
                    end
                    S_TX: begin
                        if (bitn != ACK_SLOT) begin
                            bitn <= bitn + 4'd1;
                        end else if (samp) begin
                            fail  <= 1'b1;
                            state <= S_STOP;
                        end else if (seg == SEG_OFF) begin
                            seg   <= SEG_AR;
                            state <= S_START;
                        end else if (seg == SEG_AR) begin
                            seg   <= seg + 4'd1;
                            bitn  <= '0;
                            state <= S_RX;
                        end else begin
                            seg  <= seg + 4'd1;
                            bitn <= '0;
                        end
                    end
                    S_RX: begin
                        if (bitn != ACK_SLOT) begin
                            bitn <= bitn + 4'd1;
                        end else if (seg == SEG_LAST) begin
                            state <= S_STOP;
                        end else begin
                            seg  <= seg + 4'd1;
                            bitn <= '0;
                        end
                    end
                    S_STOP:  state <= S_DONE;
                    default: ;
                endcase
            end
        end
    end

    // Result registers, captured once at the end of STOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done           <= 1'b0;
            override_valid <= 1'b0;
            src_q          <= SRC_NONE;
        end else if (tick && state == S_STOP && ph == 2'd3) begin
            done <= 1'b1;
            if (!fail) begin
                src_q          <= match;
                override_valid <= (match != SRC_NONE);
            end
        end
    end
    assign boot_src = src_q;

    // Bus line drive, decoded from state and phase.
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state)
            S_START: begin
                scl_drive_low = (ph == 2'd0 && seg != SEG_AW) || ph == 2'd3;
                sda_drive_low = ph[1];
            end
            S_TX: begin
                scl_drive_low = (ph == 2'd0) || (ph == 2'd3);
                sda_drive_low = (bitn != ACK_SLOT) && !tx_byte[tx_idx];
            end
            S_RX: begin
                scl_drive_low = (ph == 2'd0) || (ph == 2'd3);
                sda_drive_low = (bitn == ACK_SLOT) && (seg != SEG_LAST);
            end
            S_STOP: begin
                scl_drive_low = (ph == 2'd0);
                sda_drive_low = !ph[1];
            end
            default: ;
        endcase
    end

    // R10: completion is sticky and the result is frozen
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(boot_src) && $stable(override_valid));

    // R10: lines stay released once finished
    p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !scl_drive_low && !sda_drive_low);

    // R8 / R9: a NACKed phase never yields an override
    p_nack_no_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (!override_valid && boot_src == 2'b00));

    // R11: SDA moves under high SCL only inside START or STOP
    p_sda_stable_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !$past(scl_drive_low) && (sda_drive_low != $past(sda_drive_low)))
        |-> (state == S_START || state == S_STOP));

endmodule

// File: tb/boot_tag_reader_tb.sv
module boot_tag_reader_tb;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_low, sda_low, done, vld;
    logic [1:0] src;
    logic       slave_low = 1'b0;
    wire        scl_bus = ~scl_low;
    wire        sda_bus = ~(sda_low | slave_low);

    always #4 clk = ~clk;

    boot_tag_reader #(.CLK_DIV(DIV)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_i         (sda_bus),
        .scl_drive_low (scl_low),
        .sda_drive_low (sda_low),
        .done          (done),
        .override_valid(vld),
        .boot_src      (src)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // EEPROM model configuration and records
    logic [6:0]  slv_addr = 7'h52;
    bit          nack_off = 0;
    logic [63:0] slv_tag  = '0;
    logic [7:0]  got_aw, got_off, got_ar;
    int          ack_cnt, nack_cnt;

    task automatic rx_byte(output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_bus);
            b = {b[6:0], sda_bus};
        end
    endtask

    initial begin
        logic [7:0] b;
        forever begin
            @(negedge sda_bus iff scl_bus === 1'b1);
            rx_byte(b);
            if (b[0]) got_ar = b; else got_aw = b;
            if (b[7:1] != slv_addr) continue;
            @(negedge scl_bus) slave_low = 1'b1;
            @(negedge scl_bus);
            if (!b[0]) begin
                slave_low = 1'b0;
                rx_byte(got_off);
                if (!nack_off) begin
                    @(negedge scl_bus) slave_low = 1'b1;
                    @(negedge scl_bus) slave_low = 1'b0;
                end
                continue;
            end
            for (int k = 0; k < 8; k++) begin
                bit m_ack;
                for (int j = 7; j >= 0; j--) begin
                    if (!(k == 0 && j == 7)) @(negedge scl_bus);
                    slave_low = !slv_tag[56 - 8*k + j];
                end
                @(negedge scl_bus) slave_low = 1'b0;
                @(posedge scl_bus) m_ack = !sda_bus;
                if (m_ack) ack_cnt++; else nack_cnt++;
                if (!m_ack) break;
            end
        end
    end

    // Scoreboard
    typedef struct packed { logic v; logic [1:0] s; } exp_t;
    exp_t exp_q[$];

    initial begin
        forever begin
            exp_t e;
            logic v0;
            logic [1:0] s0;
            @(posedge done);
            @(negedge clk);
            e = exp_q.pop_front();
            chk(vld == e.v && src == e.s, "R4-R9 result", {vld, src}, {e.v, e.s});
            v0 = vld; s0 = src;
            repeat (100) @(negedge clk);
            // R10: result and lines frozen after completion
            chk(done && vld == v0 && src == s0 && !scl_low && !sda_low, "R10",
                {done, vld, src, scl_low, sda_low}, {1'b1, v0, s0, 2'b00});
        end
    end

    task automatic run_case(input logic [63:0] tag, input logic [6:0] addr, input bit noff,
                            input logic v, input logic [1:0] s, input string req);
        exp_t e;
        slv_tag = tag; slv_addr = addr; nack_off = noff;
        got_aw = 'x; got_off = 'x; got_ar = 'x; ack_cnt = 0; nack_cnt = 0;
        e.v = v; e.s = s;
        exp_q.push_back(e);
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1: idle outputs while reset held
        chk(!done && !vld && src == 2'b00 && !scl_low && !sda_low, "R1",
            {done, vld, src, scl_low, sda_low}, 64'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!done && !vld && src == 2'b00, "R1 pending", {done, vld, src}, 64'h0);
        wait (done);
        repeat (150) @(negedge clk);
        $display("case %s done", req);
    endtask

    initial begin
        int t0;
        int t1;
        // R11: measure one SCL period during the first case
        fork
            begin
                @(posedge rst_n);
                @(posedge scl_bus) t0 = cyc;
                @(posedge scl_bus) t1 = cyc;
                chk(t1 - t0 == 4 * DIV, "R11 period", t1 - t0, 4 * DIV);
            end
        join_none

        run_case("boot@USB", 7'h52, 0, 1'b1, 2'b01, "R4");
        // R2 / R3: transaction shape seen by the device
        chk(got_aw == 8'hA4, "R2 write address", got_aw, 8'hA4);
        chk(got_off == 8'hF8, "R2 offset", got_off, 8'hF8);
        chk(got_ar == 8'hA5, "R2 read address", got_ar, 8'hA5);
        chk(ack_cnt == 7 && nack_cnt == 1, "R3 ack pattern", {ack_cnt[7:0], nack_cnt[7:0]}, 16'h0701);

        run_case("boot@SDC", 7'h52, 0, 1'b1, 2'b10, "R5");
        run_case("boot@SPI", 7'h52, 0, 1'b1, 2'b11, "R6");
        chk(ack_cnt == 7 && nack_cnt == 1, "R3 ack pattern again", {ack_cnt[7:0], nack_cnt[7:0]}, 16'h0701);
        run_case("boot@USX", 7'h52, 0, 1'b0, 2'b00, "R7 last char");
        run_case("BOOT@USB", 7'h52, 0, 1'b0, 2'b00, "R7 case");
        run_case("boot@USB", 7'h50, 0, 1'b0, 2'b00, "R8");
        chk(got_aw == 8'hA4 && ack_cnt == 0, "R8 stopped after address", {got_aw, ack_cnt[7:0]}, 16'hA400);
        run_case("boot@SDC", 7'h52, 1, 1'b0, 2'b00, "R9");
        chk(got_off == 8'hF8 && ack_cnt == 0 && nack_cnt == 0, "R9 no read phase",
            {got_off, ack_cnt[7:0], nack_cnt[7:0]}, 24'hF80000);
        chk(exp_q.size() == 0, "R10 one done per run", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule